// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

This block is one message cell shared by several software threads. It holds a small circular queue of 64-bit words plus a status tag, and every request names a view that decides what the access means: raw access to the stored words, read or write of the tag, or a queue push/pop that either stalls or returns at once when it cannot make progress.

When a stalling access finds the cell empty (pop) or full (push), the cell answers with a stall response and remembers the requester's 6-bit thread number in a 64-bit waiting set. The next push or pop that does go through sends out a one-cycle wake pulse carrying the whole waiting set, then empties the set. An outside scheduler uses the pulse to retry the parked threads. Address decoding and thread scheduling sit outside the block.

Top module: `msg_cell`

## Requirements
- R1: After reset the tag reads E=1, F=0, T=0, queue-mode flag 1, count 0 and the log2-depth field equal to log2(DEPTH) (0x30020001 for DEPTH=8), and the queue is empty.
- R2: A tag read returns E at bit 0, F at bit 1, T at bit 16, the queue-mode flag (always 1) at bit 17, the entry count from bit 18 upward and log2(DEPTH) in bits 31:28; every other bit is 0.
- R3: Pops return words in the order they were pushed, and the read and write positions wrap modulo DEPTH, so the order holds from any starting position.
- R4: A push first clears E; when it is not stalled it stores the word if count < DEPTH, and it sets F once count equals DEPTH. A push that finds count = DEPTH stores nothing and leaves count unchanged.
- R5: A non-stalling pop on an empty cell returns 0, clears F, sets E and leaves count and stored data unchanged; a non-stalled pop that removes the last word sets E, and every pop clears F.
- R6: A stalling pop (view 2) while E=1 returns a stall response with data 0, records the requester and changes no count or stored word.
- R7: A stalling push (view 2) while F=1 returns a stall response, records the requester and stores nothing.
- R8: Any non-stalled push or pop (view 2 or 3) made while the waiting set is non-empty raises wake for exactly one cycle, alongside its response, carrying the recorded set; the set is then empty, so the next access raises no wake.
- R9: A raw read (view 0) returns the oldest word without removing it.
- R10: A raw write (view 0) replaces the newest stored word when count > 0 and has no effect when count = 0.
- R11: A tag write (view 1) changes only T, E and F (from write-data bits 16, 0 and 1); when the written E is 1 the count becomes 0, and the mode flag, depth field and read position never change.
- R12: View codes are 0 raw, 1 tag, 2 queue stalling, 3 queue non-stalling; each request gives a response in the following cycle with rsp_valid high, and write responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 2 | View code (see R12) |
| req_tid | input | 6 | Requester thread number |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_stall | output | 1 | Request was stalled and its thread recorded |
| rsp_rdata | output | 64 | Read data |
| wake_valid | output | 1 | One-cycle wake pulse |
| wake_mask | output | 64 | Threads to be woken |

## Verification
The embedded assertions watch, on every cycle, that the count never passes DEPTH, that a stall leaves the count untouched and leaves the stalled thread in the waiting set, that a wake pulse always carries a non-empty set and leaves the set empty, and that no response appears without a request. Data ordering across every wrap offset, the exact flag values after each access, the dropped push on a full cell, raw overwrite of the newest word and the tag-write masking can only be shown by the bench's sweeps, which compare read data and tag words against values it computes itself.

// File: rtl/msg_cell_pkg.sv
// Shared view codes and tag bit positions for the message cell.
// Assumes: the tag layout is decoded by software, so positions are fixed.
package msg_cell_pkg;
    typedef enum logic [1:0] {
        VIEW_RAW     = 2'd0,
        VIEW_TAG     = 2'd1,
        VIEW_EF_WAIT = 2'd2,
        VIEW_EF_TRY  = 2'd3
    } view_e;

    localparam int TAG_E_BIT    = 0;
    localparam int TAG_F_BIT    = 1;
    localparam int TAG_T_BIT    = 16;
    localparam int TAG_MODE_BIT = 17;
    localparam int TAG_CNT_LSB  = 18;
    localparam int TAG_LOG2_LSB = 28;
    localparam int TAG_LOG2_W   = 4;
endpackage

// File: rtl/msg_cell_store.sv
// Word storage of the cell: DEPTH registers of WIDTH bits, one write port,
// one asynchronous read port. Assumes the caller keeps indices in range.
module msg_cell_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Each slot captures the write data when it is the addressed entry.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    // Read port selects the slot at the read position.
    always_comb begin
        rd_data = slot_q[rd_idx];
    end
endmodule

// File: rtl/msg_cell_waiters.sv
// Waiting-set tracker: records stalled thread numbers and, on request,
// emits them as a one-cycle wake pulse and empties the set.
// Assumes wake_en and rec_en are never high together.
module msg_cell_waiters #(
    parameter int N_TID = 64,
    localparam int TID_W = $clog2(N_TID)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_en,
    input  logic [TID_W-1:0] rec_tid,
    input  logic             wake_en,
    output logic [N_TID-1:0] pend,
    output logic             wake_valid,
    output logic [N_TID-1:0] wake_mask
);
    logic [N_TID-1:0] pend_q;

    // Waiting set update and wake pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            wake_valid <= 1'b0;
            wake_mask  <= '0;
        end else if (wake_en) begin
            wake_valid <= 1'b1;
            wake_mask  <= pend_q;
            pend_q     <= '0;
        end else begin
            wake_valid <= 1'b0;
            wake_mask  <= '0;
            if (rec_en) begin
                pend_q <= pend_q | (N_TID'(1) << rec_tid);
            end
        end
    end

    assign pend = pend_q;

    a_r8_wake_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (wake_mask != '0));
    a_r8_wake_empties_set: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (pend_q == '0));
endmodule

// File: rtl/msg_cell_ctrl.sv
// View decoder and tag/pointer state of the cell. Computes, for the
// current request, the storage write, the response data, and whether the
// request stalls or wakes waiters. Assumes DEPTH is a power of two >= 2.
module msg_cell_ctrl
    import msg_cell_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_view,
    input  logic [WIDTH-1:0] req_wdata,
    input  logic [WIDTH-1:0] mem_rdata,
    input  logic             pend_any,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_widx,
    output logic [WIDTH-1:0] mem_wdata,
    output logic [IDX_W-1:0] rptr,
    output logic             stall_now,
    output logic             wake_now,
    output logic [WIDTH-1:0] rdata_now,
    output logic [WIDTH-1:0] tag_word
);
    logic             e_q, f_q, t_q;
    logic             e_n, f_n, t_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [IDX_W-1:0] rptr_q, rptr_n;
    logic             blocking;

    // Tag word assembled from the live state.
    always_comb begin
        tag_word                                  = '0;
        tag_word[TAG_E_BIT]                       = e_q;
        tag_word[TAG_F_BIT]                       = f_q;
        tag_word[TAG_T_BIT]                       = t_q;
        tag_word[TAG_MODE_BIT]                    = 1'b1;
        tag_word[TAG_CNT_LSB +: CNT_W]            = cnt_q;
        tag_word[TAG_LOG2_LSB +: TAG_LOG2_W]      = TAG_LOG2_W'(IDX_W);
    end

    // Per-view next state, storage write and response selection.
    always_comb begin
        e_n       = e_q;
        f_n       = f_q;
        t_n       = t_q;
        cnt_n     = cnt_q;
        rptr_n    = rptr_q;
        mem_we    = 1'b0;
        mem_widx  = rptr_q;
        mem_wdata = req_wdata;
        stall_now = 1'b0;
        wake_now  = 1'b0;
        rdata_now = '0;
        blocking  = (req_view == VIEW_EF_WAIT);
        if (req_valid) begin
            case (req_view)
                VIEW_RAW: begin
                    if (req_write) begin
                        if (cnt_q != '0) begin
                            mem_we   = 1'b1;
                            mem_widx = rptr_q + IDX_W'(cnt_q - CNT_W'(1));
                        end
                    end else begin
                        rdata_now = mem_rdata;
                    end
                end
                VIEW_TAG: begin
                    if (req_write) begin
                        t_n = req_wdata[TAG_T_BIT];
                        e_n = req_wdata[TAG_E_BIT];
                        f_n = req_wdata[TAG_F_BIT];
                        if (req_wdata[TAG_E_BIT]) begin
                            cnt_n = '0;
                        end
                    end else begin
                        rdata_now = tag_word;
                    end
                end
                default: begin
                    if (!req_write) begin
                        f_n = 1'b0;
                        if (blocking && e_q) begin
                            stall_now = 1'b1;
                        end else begin
                            wake_now = pend_any;
                            if (cnt_q != '0) begin
                                rdata_now = mem_rdata;
                                rptr_n    = rptr_q + IDX_W'(1);
                                cnt_n     = cnt_q - CNT_W'(1);
                            end
                            if (cnt_n == '0) begin
                                e_n = 1'b1;
                            end
                        end
                    end else begin
                        e_n = 1'b0;
                        if (blocking && f_q) begin
                            stall_now = 1'b1;
                        end else begin
                            wake_now = pend_any;
                            if (cnt_q < CNT_W'(DEPTH)) begin
                                mem_we   = 1'b1;
                                mem_widx = rptr_q + IDX_W'(cnt_q);
                                cnt_n    = cnt_q + CNT_W'(1);
                            end
                            if (cnt_n == CNT_W'(DEPTH)) begin
                                f_n = 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    // Tag and read-position registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q    <= 1'b1;
            f_q    <= 1'b0;
            t_q    <= 1'b0;
            cnt_q  <= '0;
            rptr_q <= '0;
        end else begin
            e_q    <= e_n;
            f_q    <= f_n;
            t_q    <= t_n;
            cnt_q  <= cnt_n;
            rptr_q <= rptr_n;
        end
    end

    assign rptr = rptr_q;

    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    a_r11_tag_keeps_rptr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_view == VIEW_TAG) |=> (rptr_q == $past(rptr_q)));
endmodule

// File: rtl/msg_cell.sv
// Message cell top: ties the view decoder, word storage and waiting-set
// tracker together and registers the response. Assumes at most one request
// per cycle and that the requester holds no more than one outstanding access.
module msg_cell
    import msg_cell_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 64,
    parameter int N_TID = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int TID_W = $clog2(N_TID)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_view,
    input  logic [TID_W-1:0] req_tid,
    input  logic [WIDTH-1:0] req_wdata,
    output logic             rsp_valid,
    output logic             rsp_stall,
    output logic [WIDTH-1:0] rsp_rdata,
    output logic             wake_valid,
    output logic [N_TID-1:0] wake_mask
);
    logic             mem_we;
    logic [IDX_W-1:0] mem_widx;
    logic [WIDTH-1:0] mem_wdata;
    logic [WIDTH-1:0] mem_rdata;
    logic [IDX_W-1:0] rptr;
    logic             stall_now;
    logic             wake_now;
    logic [WIDTH-1:0] rdata_now;
    logic [WIDTH-1:0] tag_word;
    logic [N_TID-1:0] pend;

    msg_cell_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_view  (req_view),
        .req_wdata (req_wdata),
        .mem_rdata (mem_rdata),
        .pend_any  (|pend),
        .mem_we    (mem_we),
        .mem_widx  (mem_widx),
        .mem_wdata (mem_wdata),
        .rptr      (rptr),
        .stall_now (stall_now),
        .wake_now  (wake_now),
        .rdata_now (rdata_now),
        .tag_word  (tag_word)
    );

    msg_cell_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_idx  (mem_widx),
        .wr_data (mem_wdata),
        .rd_idx  (rptr),
        .rd_data (mem_rdata)
    );

    msg_cell_waiters #(.N_TID(N_TID)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_en     (stall_now),
        .rec_tid    (req_tid),
        .wake_en    (wake_now),
        .pend       (pend),
        .wake_valid (wake_valid),
        .wake_mask  (wake_mask)
    );

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_stall <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_stall <= req_valid && stall_now;
            rsp_rdata <= req_valid ? rdata_now : '0;
        end
    end

    a_r12_rsp_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
    a_r6_stall_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> (tag_word == $past(tag_word) ||
                       tag_word[TAG_CNT_LSB +: IDX_W+1] == $past(tag_word[TAG_CNT_LSB +: IDX_W+1])));
    a_r7_stall_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> pend[$past(req_tid)]);
    a_r8_no_wake_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> !wake_valid);
endmodule

// File: tb/tb_msg_cell.sv
`timescale 1ns/1ps
module tb_msg_cell;
    localparam int DEPTH = 8;
    localparam int LOG2  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_view = 2'd0;
    logic [5:0]  req_tid = 6'd0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_stall, wake_valid;
    logic [63:0] rsp_rdata, wake_mask;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [63:0] r_data, r_mask;
    logic        r_stall, r_wake, r_valid;

    always #2 clk = ~clk;

    msg_cell #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_view(req_view), .req_tid(req_tid), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_stall(rsp_stall), .rsp_rdata(rsp_rdata),
        .wake_valid(wake_valid), .wake_mask(wake_mask)
    );

    function automatic logic [63:0] tagv(bit e, bit f, bit t, int c);
        return (64'(LOG2) << 28) | (64'(c) << 18) | (64'd1 << 17) |
               (64'(t) << 16) | (64'(f) << 1) | 64'(e);
    endfunction

    function automatic logic [63:0] pat(int off, int i);
        return 64'hC0DE_0000_0000_0000 | (64'(off) << 8) | 64'(i);
    endfunction

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    task automatic req(input bit wr, input logic [1:0] v, input logic [5:0] tid,
                       input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_view = v; req_tid = tid; req_wdata = d;
        @(posedge clk);
        #1;
        r_valid = rsp_valid; r_stall = rsp_stall; r_data = rsp_rdata;
        r_wake = wake_valid; r_mask = wake_mask;
        req_valid = 1'b0;
    endtask

    task automatic tag_is(input string r, input logic [63:0] exp);
        req(1'b0, 2'd1, 6'd0, 64'd0);
        chk(r, r_data, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 / R2: reset tag value and layout
        tag_is("R1 reset tag", 64'h0000_0000_3002_0001);
        chk("R12 rsp_valid", 64'(r_valid), 64'd1);
        tag_is("R2 layout", tagv(1, 0, 0, 0));

        // R5: non-stalling pop of empty cell
        req(1'b0, 2'd3, 6'd1, 64'd0);
        chk("R5 empty pop data", r_data, 64'd0);
        chk("R5 empty pop stall", 64'(r_stall), 64'd0);
        tag_is("R5 empty pop tag", tagv(1, 0, 0, 0));

        // R3 / R4 / R9: sweep every starting position
        for (int off = 0; off < DEPTH; off++) begin
            for (int k = 0; k < off; k++) begin
                req(1'b1, 2'd3, 6'd0, 64'hFFFF);
                req(1'b0, 2'd3, 6'd0, 64'd0);
            end
            for (int i = 0; i < DEPTH; i++) begin
                req(1'b1, 2'd3, 6'd0, pat(off, i));
                chk("R12 write data zero", r_data, 64'd0);
                tag_is("R4 tag after push", tagv(0, (i + 1 == DEPTH), 0, i + 1));
            end
            req(1'b1, 2'd3, 6'd0, 64'hDEAD);
            chk("R4 push on full no stall", 64'(r_stall), 64'd0);
            tag_is("R4 full count kept", tagv(0, 1, 0, DEPTH));
            req(1'b0, 2'd0, 6'd0, 64'd0);
            chk("R9 raw read oldest", r_data, pat(off, 0));
            tag_is("R9 raw read no pop", tagv(0, 1, 0, DEPTH));
            for (int i = 0; i < DEPTH; i++) begin
                req(1'b0, 2'd3, 6'd0, 64'd0);
                chk("R3 pop order", r_data, pat(off, i));
                tag_is("R5 tag after pop", tagv(i + 1 == DEPTH, 0, 0, DEPTH - 1 - i));
            end
        end

        // R6 / R8: stalling pops on empty record threads, push wakes them
        req(1'b0, 2'd2, 6'd5, 64'd0);
        chk("R6 stall on empty", 64'(r_stall), 64'd1);
        chk("R6 stall data zero", r_data, 64'd0);
        req(1'b0, 2'd2, 6'd41, 64'd0);
        chk("R6 second stall", 64'(r_stall), 64'd1);
        tag_is("R6 tag unchanged", tagv(1, 0, 0, 0));
        req(1'b1, 2'd3, 6'd2, 64'h1111);
        chk("R8 wake pulse", 64'(r_wake), 64'd1);
        chk("R8 wake mask", r_mask, (64'd1 << 5) | (64'd1 << 41));
        req(1'b1, 2'd2, 6'd2, 64'h2222);
        chk("R8 set emptied", 64'(r_wake), 64'd0);
        chk("R8 no wake mask", r_mask, 64'd0);

        // R10: raw write replaces newest
        req(1'b0, 2'd0, 6'd0, 64'h5555);
        req(1'b1, 2'd0, 6'd0, 64'h3333);
        req(1'b0, 2'd3, 6'd0, 64'd0);
        chk("R10 oldest kept", r_data, 64'h1111);
        req(1'b0, 2'd3, 6'd0, 64'd0);
        chk("R10 newest replaced", r_data, 64'h3333);

        // R7: stalling push on full
        for (int i = 0; i < DEPTH; i++) req(1'b1, 2'd2, 6'd0, 64'(100 + i));
        req(1'b1, 2'd2, 6'd3, 64'hBAD);
        chk("R7 stall on full", 64'(r_stall), 64'd1);
        tag_is("R7 count kept", tagv(0, 1, 0, DEPTH));
        req(1'b0, 2'd2, 6'd0, 64'd0);
        chk("R7 oldest returned", r_data, 64'd100);
        chk("R8 wake for pusher", r_mask, 64'd1 << 3);

        // R11: tag write masking and count reset
        req(1'b1, 2'd1, 6'd0, 64'hFFFF_FFFF_FFFE_FFFE & ~64'd1 | 64'h1_0002);
        tag_is("R11 only T E F", tagv(0, 1, 1, DEPTH - 1));
        req(1'b1, 2'd1, 6'd0, 64'h1);
        tag_is("R11 E resets count", tagv(1, 0, 0, 0));
        req(1'b0, 2'd0, 6'd0, 64'd0);
        chk("R11 rptr kept", r_data, 64'd101);

        // R10: raw write ignored at count 0
        req(1'b1, 2'd0, 6'd0, 64'h7777);
        req(1'b0, 2'd0, 6'd0, 64'd0);
        chk("R10 ignored at zero", r_data, 64'd101);
        tag_is("R10 count stays", tagv(1, 0, 0, 0));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule